// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

After reset this block walks every erase block of a NAND device and decides from the factory marking whether the block is usable. It talks to a NAND bus sequencer through a plain read-byte request and response channel. For each block it asks for the first spare-area byte of the block's first page and, when needed, of its second page. Any byte other than the erased value FFh marks the block bad.

The outcome is kept in a one-bit-per-block table. A host reads it through an index query port, with the answer one cycle later. The block also keeps a running count of bad blocks and a sticky flag that rises when the count passes the lifetime allowance of 40. The channel can only express reads, so the scan can never erase or program anything and the factory markers stay intact. A rescan can be requested once a scan has finished.

Top module: `bad_block_scanner`

## Requirements
- R1: After reset the scan starts by itself at block 0, with the table all zero, `bad_count` at 0, `over_limit` low and `scan_done` low.
- R2: Every request targets column 2048 (`rd_col` = 2048) and row `rd_row` = block*64 + page, with page 0 or 1. The channel carries reads only.
- R3: Blocks are visited in ascending order from 0 to 2047. Page 0 of a block is read first. Page 1 is read only when page 0 returned FFh.
- R4: A block is bad when the byte read from page 0 or page 1 is not FFh. Its table bit becomes 1. `bad_count` is the number of bad blocks, with each bad block counted once.
- R5: A request is transferred when `req_valid` and `req_ready` are both high at a clock edge. Until then `req_valid` and `rd_row` hold steady. The response byte is taken in the cycle in which `resp_valid` is high.
- R6: `over_limit` goes high once `bad_count` exceeds 40 and stays high until the next scan starts. The scan still covers all blocks. A count of exactly 40 leaves it low.
- R7: `scan_done` rises after the result for block 2047 has been taken. It stays high, with `bad_count` stable, until a rescan starts.
- R8: A `scan_start` pulse while `scan_done` is high clears the table, the count and `over_limit`, and runs a full new scan. A `scan_start` pulse during a scan is ignored.
- R9: When `q_en` is high with index `q_idx` and `scan_done` is high, the next cycle shows `q_valid` = 1 and `q_bad` equal to that block's table bit. When `scan_done` is low, the next cycle shows `q_valid` = 0 and `q_bad` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | Rescan request, acted on only when done |
| req_valid | output | 1 | Read request pending |
| req_ready | input | 1 | Sequencer accepts the request |
| rd_row | output | 17 | Row address: block*64 + page |
| rd_col | output | 12 | Column address, always 2048 |
| resp_valid | input | 1 | Response byte valid |
| resp_data | input | 8 | Byte read from the device |
| scan_done | output | 1 | Scan complete, table valid |
| bad_count | output | 12 | Number of bad blocks found |
| over_limit | output | 1 | Sticky: count exceeded 40 |
| q_en | input | 1 | Table query strobe |
| q_idx | input | 11 | Block index to query |
| q_valid | output | 1 | Query answer valid (one cycle after q_en) |
| q_bad | output | 1 | Queried block is bad |

## Verification
The first scan sees markers scattered over the device. It includes a block marked bad on both pages, which must be counted only once. It also includes a decoy marker on page 2, which must be ignored, and an explicit FFh, which must leave the block good. These cases separate the page-0 rule from the page-1 rule and from pages that are never consulted. Two further scans put exactly 40 and then 41 bad blocks on page 0 and on page 1, so the limit flag is tested on both sides of its threshold. They also show that a rescan clears the previous table. During a scan, queries and stray start pulses must stay without effect. Throughout, the sequencer withholds ready in a repeating pattern and answers after a delay, while a bus model checks the order of the requests and the column address against the expected request sequence.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [2:0] {
    S_REQ0  = 3'd0,
    S_WAIT0 = 3'd1,
    S_REQ1  = 3'd2,
    S_WAIT1 = 3'd3,
    S_DONE  = 3'd4
  } scan_st_e;
endpackage

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGES      = 64,
  parameter int MARK_COL   = 2048,
  parameter int COL_W      = 12,
  parameter int DATA_W     = 8,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int PG_W      = $clog2(PAGES),
  localparam int ROW_W     = BLK_W + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  input  logic              req_ready,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_data,
  output logic              req_valid,
  output logic [ROW_W-1:0]  rd_row,
  output logic [COL_W-1:0]  rd_col,
  output logic              scan_done,
  output logic              scan_clear,
  output logic              mark_we,
  output logic [BLK_W-1:0]  mark_idx
);
  localparam logic [BLK_W-1:0]  LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [DATA_W-1:0] ERASED   = '1;

  scan_st_e         state_q, state_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             waiting, marker_bad;

  assign waiting    = (state_q == S_WAIT0) || (state_q == S_WAIT1);
  assign marker_bad = resp_data != ERASED;

  // next-state process
  always_comb begin
    state_d = state_q;
    blk_d   = blk_q;
    unique case (state_q)
      S_REQ0:  if (req_ready) state_d = S_WAIT0;
      S_REQ1:  if (req_ready) state_d = S_WAIT1;
      S_WAIT0, S_WAIT1: begin
        if (resp_valid) begin
          if ((state_q == S_WAIT0) && !marker_bad) begin
            state_d = S_REQ1;
          end else if (blk_q == LAST_BLK) begin
            state_d = S_DONE;
          end else begin
            blk_d   = blk_q + 1'b1;
            state_d = S_REQ0;
          end
        end
      end
      S_DONE: begin
        if (scan_start) begin
          blk_d   = '0;
          state_d = S_REQ0;
        end
      end
      default: state_d = S_REQ0;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_REQ0;
      blk_q   <= '0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
    end
  end

  assign req_valid  = (state_q == S_REQ0) || (state_q == S_REQ1);
  assign rd_row     = {blk_q, PG_W'((state_q == S_REQ1) || (state_q == S_WAIT1))};
  assign rd_col     = COL_W'(MARK_COL);
  assign scan_done  = state_q == S_DONE;
  assign scan_clear = (state_q == S_DONE) && scan_start;
  assign mark_we    = waiting && resp_valid && marker_bad;
  assign mark_idx   = blk_q;
endmodule

// File: rtl/bbs_table.sv
module bbs_table #(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [BLK_W-1:0] widx,
  input  logic             q_en,
  input  logic [BLK_W-1:0] q_idx,
  input  logic             q_gate,
  output logic             q_valid,
  output logic             q_bad
);
  logic [NUM_BLOCKS-1:0] tbl_q, tbl_d;
  logic                  qv_d, qb_d, qv_q, qb_q;

  always_comb begin
    tbl_d = tbl_q;
    if (clr) begin
      tbl_d = '0;
    end else if (we) begin
      tbl_d[widx] = 1'b1;
    end
    qv_d = q_en && q_gate;
    qb_d = q_en && q_gate && tbl_q[q_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
      qv_q  <= 1'b0;
      qb_q  <= 1'b0;
    end else begin
      tbl_q <= tbl_d;
      qv_q  <= qv_d;
      qb_q  <= qb_d;
    end
  end

  assign q_valid = qv_q;
  assign q_bad   = qb_q;
endmodule

// File: rtl/bbs_tally.sv
module bbs_tally #(
  parameter int NUM_BLOCKS = 2048,
  parameter int MAX_BAD    = 40,
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             over
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             over_q, over_d;

  always_comb begin
    cnt_d  = cnt_q;
    over_d = over_q;
    if (clr) begin
      cnt_d  = '0;
      over_d = 1'b0;
    end else if (inc) begin
      cnt_d  = cnt_q + 1'b1;
      over_d = over_q || (cnt_d > LIMIT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      over_q <= over_d;
    end
  end

  assign count = cnt_q;
  assign over  = over_q;
endmodule

// File: rtl/bad_block_scanner.sv
module bad_block_scanner #(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGES      = 64,
  parameter int MARK_COL   = 2048,
  parameter int COL_W      = 12,
  parameter int DATA_W     = 8,
  parameter int MAX_BAD    = 40,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int PG_W      = $clog2(PAGES),
  localparam int ROW_W     = BLK_W + PG_W,
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ROW_W-1:0]  rd_row,
  output logic [COL_W-1:0]  rd_col,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_data,
  output logic              scan_done,
  output logic [CNT_W-1:0]  bad_count,
  output logic              over_limit,
  input  logic              q_en,
  input  logic [BLK_W-1:0]  q_idx,
  output logic              q_valid,
  output logic              q_bad
);
  // reset asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  logic             clr, mark_we;
  logic [BLK_W-1:0] mark_idx;

  bbs_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES), .MARK_COL(MARK_COL),
    .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .scan_start(scan_start),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .req_valid(req_valid), .rd_row(rd_row), .rd_col(rd_col),
    .scan_done(scan_done), .scan_clear(clr),
    .mark_we(mark_we), .mark_idx(mark_idx)
  );

  bbs_table #(.NUM_BLOCKS(NUM_BLOCKS)) u_table (
    .clk(clk), .rst_n(core_rst_n), .clr(clr), .we(mark_we), .widx(mark_idx),
    .q_en(q_en), .q_idx(q_idx), .q_gate(scan_done),
    .q_valid(q_valid), .q_bad(q_bad)
  );

  bbs_tally #(.NUM_BLOCKS(NUM_BLOCKS), .MAX_BAD(MAX_BAD)) u_tally (
    .clk(clk), .rst_n(core_rst_n), .clr(clr), .inc(mark_we),
    .count(bad_count), .over(over_limit)
  );
endmodule

// File: rtl/bad_block_scanner_chk.sv
module bad_block_scanner_chk #(
  parameter int MARK_COL = 2048,
  parameter int COL_W    = 12,
  parameter int PG_W     = 6,
  parameter int ROW_W    = 17,
  parameter int CNT_W    = 12,
  parameter int MAX_BAD  = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_start,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ROW_W-1:0] rd_row,
  input logic [COL_W-1:0] rd_col,
  input logic             scan_done,
  input logic [CNT_W-1:0] bad_count,
  input logic             over_limit,
  input logic             q_valid,
  input logic             q_bad
);
  // R2: fixed marker column, only pages 0 and 1
  a_r2_marker_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (rd_col == COL_W'(MARK_COL)) && (rd_row[PG_W-1:0] <= PG_W'(1)));

  // R5: request held until accepted
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(rd_row)));

  // R4: the count advances by at most one per cycle, or restarts from zero
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_count == $past(bad_count)) || (bad_count == $past(bad_count) + 1'b1)
    || (bad_count == '0));

  // R6: above the allowance the flag is up
  a_r6_over_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_count > CNT_W'(MAX_BAD)) |-> over_limit);

  // R6: sticky until a rescan is accepted
  a_r6_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (over_limit && !(scan_start && scan_done)) |=> over_limit);

  // R7: done holds until a rescan request
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !scan_start) |=> (scan_done && $stable(bad_count)));

  // R7: no requests while done
  a_r7_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !req_valid);

  // R9: no answer while the table is not complete
  a_r9_query_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scan_done) |-> (!q_valid && !q_bad));
endmodule

bind bad_block_scanner bad_block_scanner_chk #(
  .MARK_COL(MARK_COL), .COL_W(COL_W), .PG_W(PG_W), .ROW_W(ROW_W),
  .CNT_W(CNT_W), .MAX_BAD(MAX_BAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .req_valid(req_valid),
  .req_ready(req_ready), .rd_row(rd_row), .rd_col(rd_col),
  .scan_done(scan_done), .bad_count(bad_count), .over_limit(over_limit),
  .q_valid(q_valid), .q_bad(q_bad)
);

// File: tb/bad_block_scanner_bench.sv
`timescale 1ns/1ps
module bad_block_scanner_bench;
  localparam int NB    = 2048;
  localparam int PG    = 64;
  localparam int LAT   = 2;
  localparam int WDOG  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_start = 1'b0;
  logic        req_valid, req_ready = 1'b0;
  logic [16:0] rd_row;
  logic [11:0] rd_col;
  logic        resp_valid = 1'b0;
  logic [7:0]  resp_data = 8'hFF;
  logic        scan_done, over_limit, q_valid, q_bad;
  logic [11:0] bad_count;
  logic        q_en = 1'b0;
  logic [10:0] q_idx = '0;

  always #5 clk = ~clk;

  bad_block_scanner u_bad_block_scanner (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
    .req_valid(req_valid), .req_ready(req_ready), .rd_row(rd_row), .rd_col(rd_col),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .scan_done(scan_done), .bad_count(bad_count), .over_limit(over_limit),
    .q_en(q_en), .q_idx(q_idx), .q_valid(q_valid), .q_bad(q_bad)
  );

  // stimulus vectors: {block, page, marker byte, expected bad (bit 0)}
  localparam logic [31:0] VEC [0:11] = '{
    {12'd0,    4'd0, 8'h00, 8'd1},
    {12'd1,    4'd1, 8'hF0, 8'd1},
    {12'd5,    4'd0, 8'hFE, 8'd1},
    {12'd5,    4'd1, 8'h00, 8'd1},
    {12'd7,    4'd2, 8'h00, 8'd0},
    {12'd9,    4'd0, 8'hFF, 8'd0},
    {12'd100,  4'd1, 8'h7F, 8'd1},
    {12'd512,  4'd0, 8'h01, 8'd1},
    {12'd1023, 4'd0, 8'h80, 8'd1},
    {12'd1024, 4'd1, 8'hFE, 8'd1},
    {12'd2046, 4'd2, 8'h11, 8'd0},
    {12'd2047, 4'd1, 8'h00, 8'd1}
  };

  int n_checks = 0, n_fail = 0;
  int mode = 0;
  logic model_on = 1'b0;
  int n_reads = 0, order_errs = 0, col_errs = 0;
  int exp_blk = 0, exp_pg = 0;
  bit finished = 0;

  function automatic logic [7:0] marker(int md, int blk, int pg);
    logic [7:0] v;
    v = 8'hFF;
    if (md == 0) begin
      for (int i = 0; i < 12; i++)
        if (int'(VEC[i][31:20]) == blk && int'(VEC[i][19:16]) == pg) v = VEC[i][15:8];
    end else if (md == 1) begin
      if (blk % 50 == 3 && blk < 2003 && pg == 0) v = 8'h00;
    end else begin
      if (blk % 50 == 3 && pg == 1) v = 8'h3C;
    end
    return v;
  endfunction

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // sequencer model: stalls ready in a pattern, answers LAT cycles after transfer
  initial begin
    int pend, cyc, pblk, ppg;
    pend = 0; cyc = 0; pblk = 0; ppg = 0;
    forever begin
      @(negedge clk);
      resp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          resp_valid = 1'b1;
          resp_data  = marker(mode, pblk, ppg);
        end
      end
      cyc++;
      req_ready = model_on && (cyc % 3 != 1);
      if (model_on && req_valid && req_ready) begin
        n_reads++;
        pblk = int'(rd_row) / PG;
        ppg  = int'(rd_row) % PG;
        if (rd_col != 12'd2048) col_errs++;
        if (pblk != exp_blk || ppg != exp_pg) order_errs++;
        if (ppg == 0 && marker(mode, pblk, 0) == 8'hFF) begin
          exp_blk = pblk; exp_pg = 1;
        end else begin
          exp_blk = pblk + 1; exp_pg = 0;
        end
        pend = LAT;
      end
    end
  end

  task automatic wait_done();
    while (!scan_done && !finished) @(negedge clk);
  endtask

  task automatic start_scan(int md);
    @(negedge clk);
    mode = md; exp_blk = 0; exp_pg = 0; n_reads = 0; order_errs = 0; col_errs = 0;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
  endtask

  task automatic query(int idx, int ev, int eb, string tag);
    @(negedge clk);
    q_en = 1'b1; q_idx = 11'(idx);
    @(negedge clk);
    q_en = 1'b0;
    check({tag, " q_valid"}, int'(q_valid), ev);
    check({tag, " q_bad"},   int'(q_bad),   eb);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected scan completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 scan_done after reset", int'(scan_done), 0);
    check("R1 bad_count after reset", int'(bad_count), 0);
    check("R1 over_limit after reset", int'(over_limit), 0);
    repeat (3) @(negedge clk);
    model_on = 1'b1;

    // scan A: scattered markers, walked through the vector table
    wait_done();
    check("R7 done after scan A", int'(scan_done), 1);
    check("R4 count scan A", int'(bad_count), 8);
    check("R6 over scan A", int'(over_limit), 0);
    check("R3 R5 reads scan A (page1 skipped after page0 bad)", n_reads, 2 * NB - 4);
    check("R3 order scan A", order_errs, 0);
    check("R2 column scan A", col_errs, 0);
    for (int i = 0; i < 12; i++)
      query(int'(VEC[i][31:20]), 1, int'(VEC[i][0]), "R4 R9 vector");
    query(2, 1, 0, "R4 untouched block");
    begin
      logic [11:0] held;
      held = bad_count;
      repeat (10) @(negedge clk);
      check("R7 done held", int'(scan_done), 1);
      check("R7 count held", int'(bad_count), int'(held));
    end
    @(negedge clk);
    check("R9 no q_en no valid", int'(q_valid), 0);

    // scan B: exactly 40 bad on page 0
    start_scan(1);
    check("R8 done cleared by rescan", int'(scan_done), 0);
    wait_done();
    check("R4 count scan B", int'(bad_count), 40);
    check("R6 exactly limit leaves flag low", int'(over_limit), 0);
    check("R3 reads scan B", n_reads, 2 * NB - 40);
    check("R3 order scan B", order_errs, 0);
    query(0, 1, 0, "R8 table cleared block0");
    query(3, 1, 1, "R4 scan B block3");
    query(2003, 1, 0, "R4 scan B block2003");

    // scan C: 41 bad on page 1, with stray start and early query
    start_scan(2);
    repeat (100) @(negedge clk);
    query(3, 0, 0, "R9 query during scan");
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    wait_done();
    check("R4 count scan C", int'(bad_count), 41);
    check("R6 over limit scan C", int'(over_limit), 1);
    check("R8 stray start ignored reads", n_reads, 2 * NB);
    check("R8 stray start ignored order", order_errs, 0);
    check("R2 column scan C", col_errs, 0);
    query(2003, 1, 1, "R4 scan C block2003");
    query(4, 1, 0, "R4 scan C block4");
    query(0, 1, 0, "R8 scan C block0");

    finish_run();
  end
endmodule